// File: doc/BRIEF.md
# Reciprocal Dual-Counter Frequency Meter

This block finds the ratio between two clocks. A window counter closes a measurement after a programmed number of rising edges on one input. A measuring counter counts the rising edges of the other input over the same span. Software gets the unknown frequency from the two counts and the known reference frequency. Each input first passes through its own edge synchronizer, so both inputs may be asynchronous to the system clock. Each input must have a period longer than two system clock cycles.

Software drives the block through a byte-wide register port with four addresses: control, status, count high byte and count low byte. Software first pulses the clear bit. It then picks the window length with a tap code and chooses which input gates the window with an active-low swap bit. It can also place a divider in front of the oscillator input. Setting the run bit starts a measurement. When the window closes, the done flag and the interrupt pin go high and the count is frozen. Clearing the run bit drops the done flag. The count keeps its value until the next clear. This means the high and low bytes can be read in either order.

Top module: `freq_ratio_meter`

## Requirements
- R1: After reset the control register reads 0x08, the status register and both count bytes read 0x00, and irq_o is low.
- R2: With the window-terminate bit (control bit 2) set, done is set on the rising edge of the gating input that completes a count of span × PRESC. The span depends on the tap code in control bits [5:4]: code 0 gives 32, code 1 gives 128, codes 2 and 3 give 512. One edge fewer leaves done at 0.
- R3: While run (control bit 1) is set and done is clear, each rising edge of the measured input adds one to the count. Edges that arrive after done do not change the count.
- R4: With the swap bit (control bit 3) at 1, input osc_a_i gates the window and osc_b_i is measured. With the swap bit at 0, the roles are exchanged.
- R5: While the clear bit (control bit 0) is 1, the count and the overflow flag are held at zero.
- R6: While run is 0, done is cleared, edges on either input are ignored, and the count holds its last value.
- R7: With the window-terminate bit at 0, the window never closes and done stays 0 however many gating edges arrive.
- R8: The count saturates at its all-ones value. An edge that arrives at the all-ones value sets a sticky overflow flag (status bit 1), and only the clear bit resets it.
- R9: With the predivide bit (control bit 6) set, the oscillator input osc_b_i passes through a divide-by-RF_DIV stage before it is routed. The divider restarts whenever run is 0.
- R10: The register map is: address 0 is the control register, read back with bit 7 always 0. Address 1 is status, with bit 0 for done and bit 1 for overflow. Address 2 holds count bits [15:8], zero-extended. Address 3 holds count bits [7:0].
- R11: irq_o is high exactly when the status done bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_a_i | input | 1 | Reference input, asynchronous |
| osc_b_i | input | 1 | Oscillator input, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on the address |
| irq_o | output | 1 | Window-closed flag |

## Verification
An input edge is counted on the third system clock edge after the input changes: two synchronizer flops, then the edge-detect flop. Done and irq_o change on that same clock edge. A control write takes effect on the clock edge that samples the strobe. Register reads follow the address with no added delay. The driver lets at least five cycles pass after its last input pulse or write before it queues an expected value. The monitor samples one nanosecond after a rising clock edge, half a cycle after the driver has set the read address. Every sample therefore lands after all the register stages have settled.

// File: rtl/fmeter_pkg.sv
package fmeter_pkg;

   localparam int TAP_W = 10;

   typedef enum logic [1:0] {
      A_CTRL   = 2'd0,
      A_STAT   = 2'd1,
      A_CNT_HI = 2'd2,
      A_CNT_LO = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic       spare;
      logic       prediv;
      logic [1:0] tap;
      logic       swap_n;
      logic       term;
      logic       run;
      logic       clr;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{spare: 1'b0, prediv: 1'b0, tap: 2'd0,
                                  swap_n: 1'b1, term: 1'b0, run: 1'b0,
                                  clr: 1'b0};

   // number of prescaled ticks that make up one window
   function automatic logic [TAP_W-1:0] tap_span(input logic [1:0] code);
      case (code)
         2'd0:    return 10'd32;
         2'd1:    return 10'd128;
         default: return 10'd512;
      endcase
   endfunction

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], async_i};
   end

   assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/fm_prediv.sv
module fm_prediv #(
   parameter int DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rise_i,
   output logic rise_o
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("fm_prediv: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_bypass
         assign rise_o = rise_i & en;
      end else begin : g_count
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (!en)    cnt <= '0;
            else if (rise_i) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end

         assign rise_o = rise_i & en & (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/fm_window.sv
module fm_window
   import fmeter_pkg::*;
#(
   parameter int PRESC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       term,
   input  logic [1:0] tap,
   input  logic       gate_rise,
   output logic       active_o,
   output logic       done_o
);
   generate
      if (PRESC < 1) begin : g_bad_presc
         $error("fm_window: PRESC must be at least 1");
      end
   endgenerate

   logic             done_q;
   logic             tick;
   logic [TAP_W-1:0] tap_cnt;
   logic             last;

   assign active_o = run & ~done_q;

   generate
      if (PRESC == 1) begin : g_nopre
         assign tick = active_o & gate_rise;
      end else begin : g_pre
         localparam int PW = $clog2(PRESC);
         localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);
         logic [PW-1:0] pcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     pcnt <= '0;
            else if (!run)                  pcnt <= '0;
            else if (active_o && gate_rise) pcnt <= (pcnt == PLAST) ? '0 : pcnt + 1'b1;
         end

         assign tick = active_o & gate_rise & (pcnt == PLAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tap_cnt <= '0;
      else if (!run) tap_cnt <= '0;
      else if (tick) tap_cnt <= tap_cnt + 1'b1;
   end

   assign last = tick & term & (tap_cnt == tap_span(tap) - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    done_q <= 1'b0;
      else if (!run) done_q <= 1'b0;
      else if (last) done_q <= 1'b1;
   end

   assign done_o = done_q;
endmodule

// File: rtl/fm_meas_ctr.sv
module fm_meas_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cnt_en,
   input  logic             rise,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] FULL = '1;

   logic [CNT_W-1:0] cnt;
   logic             ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (cnt_en && rise) begin
         if (cnt == FULL) ovf <= 1'b1;
         else             cnt <= cnt + 1'b1;
      end
   end

   assign count_o = cnt;
   assign ovf_o   = ovf;
endmodule

// File: rtl/freq_ratio_meter.sv
module freq_ratio_meter
   import fmeter_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRESC       = 4,
   parameter int RF_DIV      = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_a_i,
   input  logic       osc_b_i,
   input  logic       reg_we_i,
   input  logic [1:0] reg_addr_i,
   input  logic [7:0] reg_wdata_i,
   output logic [7:0] reg_rdata_o,
   output logic       irq_o
);
   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
         $error("freq_ratio_meter: CNT_W must lie in 9..16");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic             a_rise, b_rise, b_div_rise, b_eff;
   logic             gate_rise, meas_rise;
   logic             active_w, done_w;
   logic [CNT_W-1:0] meas_cnt;
   logic             ovf_w;
   logic [15:0]      cnt16;
   logic             run_en, clr_on;

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_RST;
      else if (reg_we_i && reg_addr_i == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata_i & 8'h7F);
   end

   assign run_en = ctrl_q.run;
   assign clr_on = ctrl_q.clr;

   fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .async_i(osc_a_i), .rise_o(a_rise));

   fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .async_i(osc_b_i), .rise_o(b_rise));

   fm_prediv #(.DIV(RF_DIV)) u_prediv (
      .clk(clk), .rst_n(rst_n), .en(run_en), .rise_i(b_rise), .rise_o(b_div_rise));

   assign b_eff     = ctrl_q.prediv ? b_div_rise : b_rise;
   assign gate_rise = ctrl_q.swap_n ? a_rise : b_eff;
   assign meas_rise = ctrl_q.swap_n ? b_eff  : a_rise;

   fm_window #(.PRESC(PRESC)) u_window (
      .clk(clk), .rst_n(rst_n), .run(run_en), .term(ctrl_q.term),
      .tap(ctrl_q.tap), .gate_rise(gate_rise),
      .active_o(active_w), .done_o(done_w));

   fm_meas_ctr #(.CNT_W(CNT_W)) u_meas (
      .clk(clk), .rst_n(rst_n), .clr(clr_on), .cnt_en(active_w),
      .rise(meas_rise), .count_o(meas_cnt), .ovf_o(ovf_w));

   assign cnt16 = 16'(meas_cnt);

   always_comb begin
      case (reg_addr_i)
         A_CTRL:   reg_rdata_o = ctrl_q;
         A_STAT:   reg_rdata_o = {6'd0, ovf_w, done_w};
         A_CNT_HI: reg_rdata_o = cnt16[15:8];
         default:  reg_rdata_o = cnt16[7:0];
      endcase
   end

   assign irq_o = done_w;
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             clr,
   input logic             done,
   input logic [CNT_W-1:0] count,
   input logic             ovf
);
   localparam logic [CNT_W-1:0] FULL = '1;

   AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !done);                                        // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(count));                     // R6
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0 && !ovf));                         // R5
   AST_FROZEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> $stable(count));                     // R3
   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULL && !clr) |=> count == FULL);             // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);                                 // R8
endmodule

bind freq_ratio_meter fm_checker #(.CNT_W(CNT_W)) u_fm_chk (
   .clk(clk), .rst_n(rst_n), .run(run_en), .clr(clr_on),
   .done(done_w), .count(meas_cnt), .ovf(ovf_w));

// File: tb/freq_ratio_meter_tb_top.sv
module freq_ratio_meter_tb_top;
   localparam int CW = 12;
   localparam int PS = 2;
   localparam int DV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_a = 1'b0, osc_b = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   freq_ratio_meter #(.CNT_W(CW), .PRESC(PS), .RF_DIV(DV)) dut_i (
      .clk(clk), .rst_n(rst_n), .osc_a_i(osc_a), .osc_b_i(osc_b),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq));

   typedef struct {
      bit         pin;
      logic [1:0] ra;
      logic [7:0] exp;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   exp_t mon_it;
   logic [7:0] mon_got;

   // monitor: compares queued expectations half a cycle after the address is set
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         mon_it  = sb_q.pop_front();
         mon_got = mon_it.pin ? {7'd0, irq} : rdata;
         n_checks++;
         if (mon_got !== mon_it.exp) begin
            n_fail++;
            $display("FAIL %s: %s addr %0d got %02h expected %02h", mon_it.tag,
                     mon_it.pin ? "irq_o" : "reg", mon_it.ra, mon_got, mon_it.exp);
         end
      end
   end

   task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string t);
      exp_t it;
      @(negedge clk);
      addr = a;
      it.pin = 1'b0; it.ra = a; it.exp = e; it.tag = t;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic expect_irq(input logic e, input string t);
      exp_t it;
      @(negedge clk);
      it.pin = 1'b1; it.ra = 2'd0; it.exp = {7'd0, e}; it.tag = t;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      addr = 2'd0; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse(input bit on_b, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (on_b) osc_b = 1'b1; else osc_a = 1'b1;
         @(negedge clk);
         if (on_b) osc_b = 1'b0; else osc_a = 1'b0;
         @(negedge clk);
      end
      repeat (5) @(negedge clk);
   endtask

   task automatic expect_count(input int c, input string t);
      expect_reg(2'd2, 8'((c >> 8) & 8'hFF), t);
      expect_reg(2'd3, 8'(c & 8'hFF), t);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: run not complete got timeout expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // reset state
      expect_reg(2'd0, 8'h08, "R1 ctrl");
      expect_reg(2'd1, 8'h00, "R1 status");
      expect_count(0, "R1 count");
      expect_irq(1'b0, "R1 irq");

      // basic window: tap 0, a gates, b measured
      wr(8'h09); wr(8'h08);
      wr(8'h8E);
      expect_reg(2'd0, 8'h0E, "R10 ctrl bit7 reads 0");
      pulse(1'b1, 300);
      pulse(1'b0, 32*PS - 1);
      expect_reg(2'd1, 8'h00, "R2 tap0 one edge short");
      pulse(1'b0, 1);
      expect_reg(2'd1, 8'h01, "R2 tap0 done");
      expect_irq(1'b1, "R11 irq with done");
      expect_count(300, "R3 R10 count 300");
      pulse(1'b1, 5);
      expect_count(300, "R3 edges after done ignored");
      wr(8'h0C);
      expect_reg(2'd1, 8'h00, "R6 done cleared");
      expect_irq(1'b0, "R11 irq low");
      expect_count(300, "R10 count held");

      // swapped: b gates, a measured, tap 1
      wr(8'h01); wr(8'h00);
      wr(8'h16);
      pulse(1'b0, 77);
      pulse(1'b1, 128*PS - 1);
      expect_reg(2'd1, 8'h00, "R4 tap1 one edge short");
      pulse(1'b1, 1);
      expect_reg(2'd1, 8'h01, "R4 R2 tap1 done");
      expect_count(77, "R4 swapped count");
      wr(8'h00);

      // predivide on b, tap 3
      wr(8'h09); wr(8'h08);
      wr(8'h7E);
      expect_reg(2'd0, 8'h7E, "R10 ctrl readback");
      pulse(1'b1, 10);
      expect_count(10 / DV, "R9 predivided count");
      pulse(1'b0, 512*PS - 1);
      expect_reg(2'd1, 8'h00, "R2 tap3 one edge short");
      pulse(1'b0, 1);
      expect_reg(2'd1, 8'h01, "R2 tap3 done");
      expect_count(10 / DV, "R9 count after window");
      wr(8'h08);

      // no termination, then disable
      wr(8'h09); wr(8'h08);
      wr(8'h0A);
      pulse(1'b0, 32*PS + 10);
      expect_reg(2'd1, 8'h00, "R7 no done without terminate");
      pulse(1'b1, 20);
      expect_count(20, "R7 counting continues");
      wr(8'h08);
      pulse(1'b1, 5);
      pulse(1'b0, 5);
      expect_count(20, "R6 edges ignored while idle");

      // saturation and clear
      wr(8'h09); wr(8'h08);
      wr(8'h0A);
      pulse(1'b1, (1 << CW) + 4);
      expect_count((1 << CW) - 1, "R8 saturated");
      expect_reg(2'd1, 8'h02, "R8 overflow set");
      wr(8'h08);
      expect_reg(2'd1, 8'h02, "R8 overflow sticky");
      wr(8'h09);
      expect_count(0, "R5 cleared count");
      expect_reg(2'd1, 8'h00, "R5 overflow cleared");
      wr(8'h08);

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         summary();
         $finish;
      end
   end
endmodule